// File: doc/BRIEF.md
# FIFO Slice Extraction Stage

This block is the output end of a 4-bit FIFO slice. It takes the word waiting at the bottom of the stack and holds it in an output register. From there the word goes out in one of two ways. In parallel mode the whole word sits on a data bus. In serial mode it leaves one bit at a time, least significant bit first, on each falling edge of a serial clock. A status flag (`empty_n`, HIGH means valid data) tells the consumer when the register holds a word that has not yet been taken.

The parallel transfer input acts on its level. While it is HIGH, a word that reaches the stack bottom is loaded. A guard stops a single HIGH period from loading more than one word. A serial word is requested by driving the serial request LOW while the transfer input is HIGH. The serial drive then switches itself on, and it switches off once the last bit has been shifted out.

Slices can sit side by side to build a wider word. In that case a master latch, captured during master reset, picks the row master. A slave slice holds its valid flag LOW until the enable from a higher-priority slice goes HIGH. All pins are brought into a single system clock domain through synchronisers. Three-state buses are modelled as data plus drive-enable pairs.

Top module: `fifo_out_stage`

## Requirements
- R1: After system reset or a master reset pulse, `empty_n` is LOW, `ser_q_en` is LOW and the slice is in parallel mode. A master reset also drops a word already held.
- R2: When `xfer_par` is HIGH, the register is unoccupied and `stack_valid` is HIGH, the slice loads `stack_data`. It pulses `stack_take` for exactly one cycle, `par_q` then equals the loaded word, and on a master slice `empty_n` goes HIGH.
- R3: In parallel mode, `xfer_par` going LOW drives `empty_n` LOW. The last loaded word stays on `par_q` until the next load.
- R4: One continuous HIGH period of `xfer_par` loads at most one word in parallel mode.
- R5: `xfer_par` is level-sensitive. A word that arrives while it is HIGH is loaded. A HIGH period that ends before any word arrives leaves `empty_n` LOW.
- R6: A load made while `xfer_ser_n` is LOW enters serial mode. In this mode `ser_q_en` is HIGH, `par_q_en` is LOW and `ser_q` carries bit 0 of the word.
- R7: In serial mode, each falling edge of `sclk` shifts the word one place toward bit 0, so `ser_q` shows bits 1, 2 and 3 in turn. The WIDTH-th falling edge drives `empty_n` and `ser_q_en` LOW and frees the register for the next word.
- R8: While `mreset` is HIGH, the master latch takes the value of `master_sel`. When the latch is clear, a held word keeps `empty_n` LOW until `slave_en` is HIGH.
- R9: `par_q_en` is HIGH exactly when `oe_n` is LOW and the slice is not in serial mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| mreset | input | 1 | Master reset pin, active HIGH, asynchronous to clk |
| master_sel | input | 1 | Row-master select, captured during master reset |
| xfer_par | input | 1 | Level-sensitive transfer request |
| xfer_ser_n | input | 1 | Serial transfer request, active LOW |
| sclk | input | 1 | Serial output clock; shifts on its falling edge |
| slave_en | input | 1 | Enable from the higher-priority slice |
| oe_n | input | 1 | Parallel output enable, active LOW |
| stack_valid | input | 1 | Stack bottom holds a word |
| stack_data | input | WIDTH | Word at the stack bottom |
| stack_take | output | 1 | One-cycle pop strobe to the stack |
| par_q | output | WIDTH | Parallel data out |
| par_q_en | output | 1 | Parallel bus drive enable |
| ser_q | output | 1 | Serial data out |
| ser_q_en | output | 1 | Serial line drive enable |
| empty_n | output | 1 | HIGH when the register holds a valid word |

## Verification
The assertions assume that the stack removes its bottom word in the cycle after `stack_take` and does not change `stack_data` while a load is pending. They also assume that pins stay at a level for longer than the synchroniser depth, so that no pulse is lost. The stimulus changes pins only on falling clock edges and holds each level for six cycles. The bench's stack model pops one cycle after it sees `stack_take`. Serial clock phases are held long enough that each falling edge is seen exactly once.

// File: rtl/fifo_out_pkg.sv
package fifo_out_pkg;
  typedef enum logic {
    MODE_PAR = 1'b0,
    MODE_SER = 1'b1
  } xfer_mode_e;
endpackage

// File: rtl/fifo_out_sync.sv
module fifo_out_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[i] <= RST_VAL;
        else     st[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[i] <= RST_VAL;
        else     st[i] <= st[i-1];
      end
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/fifo_out_ctrl.sv
module fifo_out_ctrl
  import fifo_out_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       top_s,
  input  logic       tos_n_s,
  input  logic       sclk_s,
  input  logic       mr_s,
  input  logic       msel_s,
  input  logic       stack_valid,
  output logic       load,
  output logic       shift,
  output logic       held,
  output xfer_mode_e mode,
  output logic       master
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic          sclk_d;
  logic          sclk_fall;
  logic [CW-1:0] cnt;

  assign sclk_fall = sclk_d & ~sclk_s;
  assign load  = ~rst & ~mr_s & top_s & ~held & stack_valid;
  assign shift = ~mr_s & held & (mode == MODE_SER) & sclk_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      held   <= 1'b0;
      mode   <= MODE_PAR;
      cnt    <= '0;
      master <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      if (mr_s) begin
        held   <= 1'b0;
        mode   <= MODE_PAR;
        cnt    <= '0;
        master <= msel_s;
      end else if (load) begin
        held <= 1'b1;
        mode <= tos_n_s ? MODE_PAR : MODE_SER;
        cnt  <= '0;
      end else if (held) begin
        if (mode == MODE_PAR) begin
          if (!top_s) held <= 1'b0;
        end else if (shift) begin
          if (cnt == LAST) begin
            held <= 1'b0;
            cnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/fifo_out_shreg.sv
module fifo_out_shreg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= din;
    else if (shift) q <= {1'b0, q[WIDTH-1:1]};
  end
endmodule

// File: rtl/fifo_out_stage.sv
module fifo_out_stage
  import fifo_out_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mreset,
  input  logic             master_sel,
  input  logic             xfer_par,
  input  logic             xfer_ser_n,
  input  logic             sclk,
  input  logic             slave_en,
  input  logic             oe_n,
  input  logic             stack_valid,
  input  logic [WIDTH-1:0] stack_data,
  output logic             stack_take,
  output logic [WIDTH-1:0] par_q,
  output logic             par_q_en,
  output logic             ser_q,
  output logic             ser_q_en,
  output logic             empty_n
);
  localparam int NHI = 5;
  localparam int NLO = 2;

  logic [NHI-1:0] hi_s;
  logic [NLO-1:0] lo_s;
  logic           top_s, sclk_s, oes_s, mr_s, msel_s, tos_n_s, oe_n_s;
  logic           load, shift, held, master;
  xfer_mode_e     mode;
  logic [WIDTH-1:0] data_q;

  fifo_out_sync #(.WIDTH(NHI), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_hi (
    .clk(clk), .rst(rst),
    .d({xfer_par, sclk, slave_en, mreset, master_sel}),
    .q(hi_s)
  );

  fifo_out_sync #(.WIDTH(NLO), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync_lo (
    .clk(clk), .rst(rst),
    .d({xfer_ser_n, oe_n}),
    .q(lo_s)
  );

  assign {top_s, sclk_s, oes_s, mr_s, msel_s} = hi_s;
  assign {tos_n_s, oe_n_s} = lo_s;

  fifo_out_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst),
    .top_s(top_s), .tos_n_s(tos_n_s), .sclk_s(sclk_s),
    .mr_s(mr_s), .msel_s(msel_s), .stack_valid(stack_valid),
    .load(load), .shift(shift), .held(held), .mode(mode), .master(master)
  );

  fifo_out_shreg #(.WIDTH(WIDTH)) u_shreg (
    .clk(clk), .rst(rst), .load(load), .shift(shift),
    .din(stack_data), .q(data_q)
  );

  assign stack_take = load;
  assign par_q      = data_q;
  assign ser_q      = data_q[0];
  assign ser_q_en   = held & (mode == MODE_SER);
  assign par_q_en   = ~oe_n_s & (mode == MODE_PAR);
  assign empty_n    = held & (master | oes_s);
endmodule

// File: rtl/fifo_out_stage_chk.sv
module fifo_out_stage_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             stack_valid,
  input logic [WIDTH-1:0] stack_data,
  input logic             stack_take,
  input logic [WIDTH-1:0] par_q,
  input logic             par_q_en,
  input logic             ser_q_en,
  input logic             empty_n
);
  // R1
  reset_flag_chk: assert property (@(posedge clk) rst |=> (!empty_n && !ser_q_en));

  // R2
  take_valid_chk: assert property (@(posedge clk) disable iff (rst)
    stack_take |-> stack_valid);

  // R2
  load_data_chk: assert property (@(posedge clk) disable iff (rst)
    stack_take |=> (par_q == $past(stack_data)));

  // R4
  take_single_chk: assert property (@(posedge clk) disable iff (rst)
    stack_take |=> !stack_take);

  // R3
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    (!stack_take && !ser_q_en) |=> $stable(par_q));

  // R9
  drive_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ser_q_en |-> !par_q_en);
endmodule

bind fifo_out_stage fifo_out_stage_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .stack_valid(stack_valid), .stack_data(stack_data),
  .stack_take(stack_take), .par_q(par_q), .par_q_en(par_q_en),
  .ser_q_en(ser_q_en), .empty_n(empty_n)
);

// File: tb/fifo_out_stage_test.sv
module fifo_out_stage_test;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mreset = 1'b0, master_sel = 1'b1, xfer_par = 1'b0, xfer_ser_n = 1'b1;
  logic sclk = 1'b0, slave_en = 1'b0, oe_n = 1'b0;
  logic stack_valid, stack_take, par_q_en, ser_q, ser_q_en, empty_n;
  logic [W-1:0] stack_data, par_q;

  int total = 0;
  int bad = 0;

  logic [W-1:0] smem [0:63];
  int wr = 0;
  int rd = 0;
  logic pend = 1'b0;

  always #5 clk = ~clk;

  assign stack_valid = (rd < wr);
  assign stack_data  = smem[rd[5:0]];

  always @(negedge clk) begin
    if (pend) rd = rd + 1;
    pend = stack_take;
  end

  fifo_out_stage #(.WIDTH(W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .mreset(mreset), .master_sel(master_sel),
    .xfer_par(xfer_par), .xfer_ser_n(xfer_ser_n), .sclk(sclk),
    .slave_en(slave_en), .oe_n(oe_n), .stack_valid(stack_valid),
    .stack_data(stack_data), .stack_take(stack_take), .par_q(par_q),
    .par_q_en(par_q_en), .ser_q(ser_q), .ser_q_en(ser_q_en), .empty_n(empty_n)
  );

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [W-1:0] v);
    smem[wr[5:0]] = v;
    wr = wr + 1;
  endtask

  task automatic do_mr(input logic sel);
    master_sel = sel;
    mreset = 1'b1;
    settle();
    mreset = 1'b0;
    settle();
  endtask

  task automatic sclk_pulse();
    sclk = 1'b1;
    settle();
    sclk = 1'b0;
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle();
    // R1 reset state
    chk("R1 empty_n after reset", empty_n, 0);
    chk("R1 ser_q_en after reset", ser_q_en, 0);
    chk("R1 take after reset", stack_take, 0);
    chk("R9 par_q_en after reset", par_q_en, 1);

    do_mr(1'b1);

    // R2 parallel load
    push(4'hA);
    push(4'h5);
    xfer_par = 1'b1;
    settle();
    chk("R2 empty_n after load", empty_n, 1);
    chk("R2 par_q after load", par_q, 4'hA);
    chk("R2 one pop", rd, 1);
    // R4 no second load in same HIGH period
    settle();
    chk("R4 pops during long HIGH", rd, 1);
    chk("R4 par_q during long HIGH", par_q, 4'hA);

    // R3 release
    xfer_par = 1'b0;
    settle();
    chk("R3 empty_n after release", empty_n, 0);
    chk("R3 par_q retained", par_q, 4'hA);

    xfer_par = 1'b1;
    settle();
    chk("R2 second word", par_q, 4'h5);
    chk("R2 second pop", rd, 2);
    chk("R2 empty_n second", empty_n, 1);
    xfer_par = 1'b0;
    settle();

    // R5 HIGH with no data
    xfer_par = 1'b1;
    settle();
    chk("R5 empty_n no data", empty_n, 0);
    xfer_par = 1'b0;
    settle();
    chk("R5 empty_n after empty pulse", empty_n, 0);
    // R5 data arriving while HIGH
    xfer_par = 1'b1;
    settle();
    push(4'h3);
    settle();
    chk("R5 late data loaded", par_q, 4'h3);
    chk("R5 late data flag", empty_n, 1);
    xfer_par = 1'b0;
    settle();

    // R9 output enable
    oe_n = 1'b1;
    settle();
    chk("R9 par_q_en disabled", par_q_en, 0);
    oe_n = 1'b0;
    settle();
    chk("R9 par_q_en enabled", par_q_en, 1);

    // R6 R7 serial sweep over every word value
    xfer_ser_n = 1'b0;
    xfer_par = 1'b1;
    settle();
    for (int v = 0; v < 16; v++) begin
      push(W'(v));
      settle();
      chk("R6 empty_n serial load", empty_n, 1);
      chk("R6 ser_q_en on", ser_q_en, 1);
      chk("R6 par_q_en off", par_q_en, 0);
      chk("R6 first bit", ser_q, (v >> 0) & 1);
      for (int k = 1; k < W; k++) begin
        sclk_pulse();
        chk("R7 shifted bit", ser_q, (v >> k) & 1);
        chk("R7 still valid", empty_n, 1);
      end
      sclk_pulse();
      chk("R7 empty after last shift", empty_n, 0);
      chk("R7 ser_q_en off", ser_q_en, 0);
    end
    chk("R7 pops after sweep", rd, 19);
    xfer_ser_n = 1'b1;
    xfer_par = 1'b0;
    settle();
    chk("R9 par_q_en off while serial mode kept", par_q_en, 0);

    // R8 slave slice
    do_mr(1'b0);
    chk("R1 parallel mode after mreset", par_q_en, 1);
    slave_en = 1'b0;
    push(4'h9);
    xfer_par = 1'b1;
    settle();
    chk("R8 slave loaded", par_q, 4'h9);
    chk("R8 slave pop", rd, 20);
    chk("R8 slave flag held low", empty_n, 0);
    slave_en = 1'b1;
    settle();
    chk("R8 slave flag with enable", empty_n, 1);
    slave_en = 1'b0;
    settle();
    chk("R8 slave flag enable dropped", empty_n, 0);
    xfer_par = 1'b0;
    settle();

    // R1 master reset drops held word
    do_mr(1'b1);
    push(4'h6);
    xfer_par = 1'b1;
    settle();
    chk("R2 master load", empty_n, 1);
    mreset = 1'b1;
    settle();
    chk("R1 mreset clears flag", empty_n, 0);
    mreset = 1'b0;
    xfer_par = 1'b0;
    settle();
    chk("R1 flag after mreset", empty_n, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule